// File: doc/BRIEF.md
# Multi-Cycle Multiply/Divide Unit with HI/LO Result Registers

This block sits in the execute stage of a 32-bit load/store pipeline and owns the two architectural result registers, HI and LO. A single-cycle `start` pulse launches one of four operations on two operands: signed or unsigned multiply, or signed or unsigned divide. The unit then reports `busy` for a fixed number of cycles. At the end of that time it writes the full 64-bit product, or the quotient and remainder, into HI and LO in one step. The pipeline stalls on `busy`. HI and LO are always driven on the outputs, so a later move-from instruction can read them directly.

A second, independent path lets the pipeline load operand `opa` straight into HI or LO, which move-to-HI and move-to-LO instructions need. The pins are control and status, not a data stream. `start` and `wr_en` are one-cycle commands. `busy` is the only back-pressure, and any command issued while `busy` is high is dropped rather than queued. The pipeline must therefore hold the instruction until `busy` is low.

Top module: `mdu_hilo`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears HI, LO and `busy` to zero.
- R2: `op` encodes 0 = unsigned multiply, 1 = signed multiply, 2 = unsigned divide and 3 = signed divide. `op`, `opa` and `opb` are captured at the edge where an idle unit sees `start`, and later changes to them do not affect the result.
- R3: `busy` rises at the edge that accepts `start` and stays high for exactly 5 cycles for a multiply and 10 cycles for a divide.
- R4: HI and LO keep their previous values while `busy` is high and both change at the edge where `busy` falls.
- R5: A multiply places bits 63:32 of the 64-bit product in HI and bits 31:0 in LO. The product is two's-complement for op 1 and unsigned for op 0.
- R6: A divide places the quotient in LO and the remainder in HI. Signed division truncates toward zero and the remainder takes the sign of the dividend. The most negative value divided by -1 yields LO = 0x80000000 and HI = 0.
- R7: Division by zero completes with the normal divide latency and returns LO = 0xFFFFFFFF and HI = the dividend. No error is signalled.
- R8: With `wr_en` high while idle, `opa` is written at that edge into LO when `wr_sel` = 0, or into HI when `wr_sel` = 1. The other register is unchanged.
- R9: A `start` seen while `busy` is high is ignored. Neither the busy length nor the in-flight result changes.
- R10: A `wr_en` seen while `busy` is high is ignored. HI and LO do not change on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle launch command |
| op | input | 2 | Operation select (see R2) |
| opa | input | 32 | First operand / dividend; data for the direct write |
| opb | input | 32 | Second operand / divisor |
| wr_en | input | 1 | Direct HI/LO write command |
| wr_sel | input | 1 | Direct write target: 0 = LO, 1 = HI |
| busy | output | 1 | Operation in progress |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |

## Verification
If the edge that accepts `start` is edge k, `busy` is high after edges k through k+N-1, with N = 5 for a multiply or 10 for a divide. The result is visible after edge k+N, and a direct write is visible after its own edge. The bench drives every input just after a rising edge and samples one nanosecond later. At each of those N+1 sample points it checks `busy`, the hold of HI/LO, and finally the result. It sweeps all four operations over a grid of corner operands, with expected values computed by integer arithmetic in the bench.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    MDU_MULU = 2'd0,
    MDU_MUL  = 2'd1,
    MDU_DIVU = 2'd2,
    MDU_DIV  = 2'd3
  } mdu_op_e;

  // bit 1 of the code separates divide from multiply, bit 0 selects signed
  function automatic logic op_is_div(input mdu_op_e o);
    return o[1];
  endfunction

  function automatic logic op_is_signed(input mdu_op_e o);
    return o[0];
  endfunction
endpackage

// File: rtl/mdu_seq.sv
module mdu_seq
  import mdu_pkg::*;
#(
  parameter int MUL_CYCLES = 5,
  parameter int DIV_CYCLES = 10
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  mdu_op_e op,
  output logic    busy,
  output logic    launch,
  output logic    finish
);
  localparam int MAXC = (MUL_CYCLES > DIV_CYCLES) ? MUL_CYCLES : DIV_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  assign busy     = (cnt != '0);
  assign launch   = start && !busy;
  assign finish   = (cnt == CW'(1));
  assign load_val = op_is_div(op) ? CW'(DIV_CYCLES) : CW'(MUL_CYCLES);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (launch) cnt <= load_val;
    else if (busy)   cnt <= cnt - CW'(1);
  end

  a_r3_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(MAXC));
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/mdu_arith.sv
module mdu_arith
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  mdu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] hi_res,
  output logic [W-1:0] lo_res
);
  localparam int W2 = 2 * W;

  logic          sgn;
  logic [W2-1:0] ext_a, ext_b, prod;
  logic          neg_a, neg_b;
  logic [W-1:0]  mag_a, mag_b, uq, ur, q, r;

  assign sgn = op_is_signed(op);

  // one 2W-bit multiplier serves both flavours: extension picks the meaning
  assign ext_a = {{W{sgn & a[W-1]}}, a};
  assign ext_b = {{W{sgn & b[W-1]}}, b};
  assign prod  = ext_a * ext_b;

  // divide on magnitudes, then restore signs (truncation toward zero)
  assign neg_a = sgn & a[W-1];
  assign neg_b = sgn & b[W-1];
  assign mag_a = neg_a ? (~a + W'(1)) : a;
  assign mag_b = neg_b ? (~b + W'(1)) : b;

  always_comb begin
    if (mag_b == '0) begin
      uq = '0;
      ur = '0;
    end else begin
      uq = mag_a / mag_b;
      ur = mag_a % mag_b;
    end
    q = (neg_a ^ neg_b) ? (~uq + W'(1)) : uq;
    r = neg_a ? (~ur + W'(1)) : ur;
  end

  always_comb begin
    if (!op_is_div(op)) begin
      hi_res = prod[W2-1:W];
      lo_res = prod[W-1:0];
    end else if (b == '0) begin
      hi_res = a;
      lo_res = '1;
    end else begin
      hi_res = r;
      lo_res = q;
    end
  end
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int W          = 32,
  parameter int MUL_CYCLES = 5,
  parameter int DIV_CYCLES = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         wr_en,
  input  logic         wr_sel,
  output logic         busy,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic         launch, finish;
  mdu_op_e      op_q;
  logic [W-1:0] a_q, b_q, hi_res, lo_res;

  mdu_seq #(.MUL_CYCLES(MUL_CYCLES), .DIV_CYCLES(DIV_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .op(mdu_op_e'(op)),
    .busy(busy), .launch(launch), .finish(finish)
  );

  // operands held for the whole operation: the arithmetic is a multicycle path
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= MDU_MULU;
      a_q  <= '0;
      b_q  <= '0;
    end else if (launch) begin
      op_q <= mdu_op_e'(op);
      a_q  <= opa;
      b_q  <= opb;
    end
  end

  mdu_arith #(.W(W)) u_arith (
    .op(op_q), .a(a_q), .b(b_q), .hi_res(hi_res), .lo_res(lo_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
    end else if (finish) begin
      hi <= hi_res;
      lo <= lo_res;
    end else if (wr_en && !busy) begin
      if (wr_sel) hi <= opa;
      else        lo <= opa;
    end
  end

  a_r4_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(hi) && $stable(lo)));
  a_r7_div_by_zero: assert property (@(posedge clk) disable iff (rst)
    (finish && op_q[1] && b_q == '0) |=> (lo == '1 && hi == $past(a_q)));
  a_r8_write_lo: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !busy && !wr_sel && !rst) |-> (lo == $past(opa)));
  a_r10_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && !finish) |=> ($stable(hi) && $stable(lo)));
endmodule

// File: tb/mdu_hilo_test.sv
`timescale 1ns/1ps
module mdu_hilo_test;
  logic        clk = 1'b0;
  logic        rst, start, wr_en, wr_sel;
  logic [1:0]  op;
  logic [31:0] opa, opb, hi, lo;
  logic        busy;
  int          n_cmp = 0, n_bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  mdu_hilo uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .wr_en(wr_en), .wr_sel(wr_sel), .busy(busy), .hi(hi), .lo(lo)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_res(input logic [1:0] o, input logic [31:0] a,
                            input logic [31:0] b, output logic [31:0] eh,
                            output logic [31:0] el);
    logic signed [63:0] sp;
    logic [63:0] up;
    int sa, sb;
    sa = a; sb = b;
    case (o)
      2'd0: begin up = {32'd0, a} * {32'd0, b}; eh = up[63:32]; el = up[31:0]; end
      2'd1: begin sp = 64'(sa) * 64'(sb); eh = sp[63:32]; el = sp[31:0]; end
      default: begin
        if (b == 0) begin eh = a; el = 32'hFFFF_FFFF; end
        else if (o == 2'd2) begin eh = a % b; el = a / b; end
        else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
          eh = 0; el = 32'h8000_0000;
        end else begin eh = sa % sb; el = sa / sb; end
      end
    endcase
  endtask

  // disturb: 0 none, 1 second start while busy (R9), 2 write while busy (R10)
  task automatic run_op(input logic [1:0] o, input logic [31:0] a,
                        input logic [31:0] b, input int disturb);
    logic [31:0] eh, el, h0, l0;
    int n;
    n = o[1] ? 10 : 5;
    h0 = hi; l0 = lo;
    expect_res(o, a, b, eh, el);
    op = o; opa = a; opb = b; start = 1;
    step();
    start = 0; opa = ~a; opb = b ^ 32'h5A5A_0001; op = ~o;   // R2: later inputs must not matter
    for (int c = 0; c < n; c++) begin
      chk(busy == 1'b1, o[1] ? "R3 div busy" : "R3 mul busy", 64'(busy), 64'd1);
      chk(hi == h0 && lo == l0, "R4 hold", {hi, lo}, {h0, l0});
      if (c == 1 && disturb == 1) begin start = 1; op = 2'd3; end
      if (c == 1 && disturb == 2) begin wr_en = 1; wr_sel = c[0]; end
      step();
      start = 0; wr_en = 0;
      if (c == 1 && disturb == 2)
        chk(hi == h0 && lo == l0, "R10 write ignored", {hi, lo}, {h0, l0});
    end
    chk(busy == 1'b0, disturb == 1 ? "R9 busy length" : "R3 busy falls", 64'(busy), 64'd0);
    chk(hi == eh && lo == el,
        disturb == 1 ? "R9 result" : (b == 0 && o[1]) ? "R7 div zero" :
        o[1] ? "R6 divide" : "R5 multiply", {hi, lo}, {eh, el});
  endtask

  task automatic direct_write(input logic sel, input logic [31:0] d);
    logic [31:0] h0, l0;
    h0 = hi; l0 = lo;
    wr_en = 1; wr_sel = sel; opa = d;
    step();
    wr_en = 0;
    if (sel) chk(hi == d && lo == l0, "R8 write hi", {hi, lo}, {d, l0});
    else     chk(lo == d && hi == h0, "R8 write lo", {hi, lo}, {h0, d});
  endtask

  logic [31:0] vals [10] = '{32'd0, 32'd1, 32'd2, 32'd7, 32'hFFFF_FFFF,
                             32'hFFFF_FFFE, 32'h8000_0000, 32'h7FFF_FFFF,
                             32'h1234_5678, 32'hDEAD_BEEF};

  initial begin
    rst = 1; start = 0; wr_en = 0; wr_sel = 0; op = 0; opa = 0; opb = 0;
    step(); step();
    rst = 0;
    chk(hi == 0 && lo == 0 && busy == 0, "R1 reset", {hi, lo}, 64'd0);
    direct_write(1'b0, 32'hCAFE_0001);
    direct_write(1'b1, 32'hBEEF_0002);
    run_op(2'd1, 32'd3, 32'hFFFF_FFFB, 2);   // write while busy
    run_op(2'd0, 32'd100, 32'd200, 1);       // start while busy
    run_op(2'd2, 32'd99, 32'd7, 1);
    run_op(2'd3, 32'hFFFF_FFF9, 32'd2, 0);   // -7/2 -> q=-3 r=-1
    run_op(2'd3, 32'd7, 32'hFFFF_FFFE, 0);   // 7/-2 -> q=-3 r=1
    for (int o = 0; o < 4; o++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_op(2'(o), vals[i], vals[j], 0);
    direct_write(1'b1, 32'h0000_00A5);
    direct_write(1'b0, 32'h5A00_0000);
    rst = 1;
    step();
    rst = 0;
    chk(hi == 0 && lo == 0 && busy == 0, "R1 reset again", {hi, lo}, 64'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule